// File: doc/BRIEF.md
# Parallel 8080 Panel Write Engine

This block feeds a command-mode LCD panel across an 8080-style parallel bus. Pixels arrive on a ready/valid stream and each one is placed on the panel bus inside one write cycle. The cycle is framed by an active-low chip select and an active-low write strobe. Its four phases (select setup, strobe setup, strobe active, strobe hold) each take a programmable number of clock cycles.

A frame is a programmed number of pixel words. It starts either on a software trigger command written to the trigger word, or on a rising edge of the panel's tearing-effect line. The tearing-effect line is synchronised first and can be gated by enable and mask bits. When the last word has been written, a sticky done-pending bit is set. This bit drives the interrupt output through an enable bit. A trigger that arrives while a frame is in flight is ignored, so the panel never sees a second start.

Software programs the block through a single-cycle write port. The word addresses are:

- 0: interface configuration
- 1: trigger control
- 2: frame length
- 3: interrupt enable
- 4: pending clear

Top module: `p8080_write_engine`

## Requirements
- R1: After reset, `lcd_cs_n_o` and `lcd_wr_n_o` are high, and `pix_ready_o`, `trig_busy_o`, `irq_pend_o` and `irq_o` are low.
- R2: The configuration word at address 0 holds four phase lengths: select setup S in bits 19:16, strobe setup W in 15:12, strobe active A in 11:8 and hold H in 7:4. Within each pixel, the write strobe falls S+W+2 cycles after chip select falls. It stays low A+1 cycles, and chip select rises H+1 cycles after the strobe rises.
- R3: A pixel is accepted only while chip select is high. Between two pixels of a frame, chip select is high for exactly one cycle. The accepted word is on `lcd_data_o` while the strobe is low and stays stable while chip select is low.
- R4: A frame of length N (address 2) produces exactly N strobes. The done-pending bit is set one cycle after chip select rises for the last pixel. A length of 0 sets the pending bit on the second edge after the trigger write, with no strobe.
- R5: A write to address 1 with bits 0 and 1 both set starts a frame. A write with bit 1 set and bit 0 clear starts nothing.
- R6: A rising edge of `te_i` starts a frame when the stored trigger word has bit 3 (hardware enable) set and bit 4 (mask) clear. With bit 4 set, tearing-effect edges start nothing.
- R7: With bit 31 of the trigger word set, every tearing-effect edge may start a frame. With it clear, only the first edge after a write of the trigger word with bit 3 set starts a frame.
- R8: A trigger of either kind that arrives while a frame is in flight is ignored. The frame keeps its length, and no further frame follows.
- R9: `trig_busy_o` is high from the start of a frame until its done event when bit 0 at address 3 is set. When that bit is clear, it stays low throughout the frame.
- R10: The pending bit stays set until a write to address 4 with bit 0 set. A write there with bit 0 clear leaves it alone. `irq_o` equals the pending bit ANDed with bit 0 of address 3.
- R11: A done event and a pending-clear write in the same cycle leave the pending bit set.
- R12: While bit 0 of the configuration word is clear, no trigger starts a frame.
- R13: Phase lengths are captured when a frame starts. A configuration write during a frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| te_i | input | 1 | Tearing-effect pulse from the panel (asynchronous) |
| pix_valid_i | input | 1 | Pixel stream valid |
| pix_data_i | input | PIX_W | Pixel stream data |
| pix_ready_o | output | 1 | Pixel stream ready |
| lcd_cs_n_o | output | 1 | Panel chip select, active low |
| lcd_wr_n_o | output | 1 | Panel write strobe, active low |
| lcd_data_o | output | PIX_W | Panel data bus |
| trig_busy_o | output | 1 | Trigger lock held while a frame is in flight |
| irq_pend_o | output | 1 | Sticky frame-done pending bit |
| irq_o | output | 1 | Frame-done interrupt |

## Verification
The frame-done event and a software write that clears the pending bit can land on the same clock edge. The bench provokes this by watching the strobe rise on the final pixel. It then counts the programmed hold length plus one further cycle, and places the clear write on exactly the edge where the done event is registered. The result is judged by the pending bit and the interrupt reading high afterwards, and a clear on the following cycle must then drop both. A trigger issued in the middle of a frame is a second collision: it must leave the strobe count and the single done event unchanged.

// File: rtl/p8080_pkg.sv
// Package: shared types and register encodings of the 8080 write engine.
// Assumes a 32-bit register write port; phase fields are 4 bits each.
package p8080_pkg;

    localparam int PH_W = 4;

    // register word addresses
    localparam logic [2:0] A_IFCFG  = 3'd0;
    localparam logic [2:0] A_TRIG   = 3'd1;
    localparam logic [2:0] A_FLEN   = 3'd2;
    localparam logic [2:0] A_IRQEN  = 3'd3;
    localparam logic [2:0] A_IRQCLR = 3'd4;

    // interface configuration bit positions
    localparam int CFG_EN_BIT    = 0;
    localparam int CFG_HOLD_LSB  = 4;
    localparam int CFG_ACT_LSB   = 8;
    localparam int CFG_WSET_LSB  = 12;
    localparam int CFG_CSSET_LSB = 16;

    // trigger control bit positions
    localparam int TRG_MODE_BIT  = 0;
    localparam int TRG_CMD_BIT   = 1;
    localparam int TRG_HWEN_BIT  = 3;
    localparam int TRG_MASK_BIT  = 4;
    localparam int TRG_EVERY_BIT = 31;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CSSET = 3'd1,
        PH_WRSET = 3'd2,
        PH_WRACT = 3'd3,
        PH_HOLD  = 3'd4
    } phase_e;

    typedef struct packed {
        logic [PH_W-1:0] cs_setup;
        logic [PH_W-1:0] wr_setup;
        logic [PH_W-1:0] wr_active;
        logic [PH_W-1:0] wr_hold;
    } phase_cfg_t;

endpackage

// File: rtl/p8080_te_sync.sv
// Tearing-effect synchroniser: brings the asynchronous panel pulse into the
// clock domain through STAGES flops and flags its rising edge for one cycle.
// Assumes STAGES >= 2.
module p8080_te_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic te_i,
    output logic te_rise_o
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // first flop samples the raw line
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= te_i;
            end
        end else begin : g_next
            // later flops settle the sampled level
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    // previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign te_rise_o = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/p8080_trigger.sv
// Trigger arbiter: turns software commands and tearing-effect edges into a
// single frame-start pulse, drops triggers while a frame is in flight and
// holds the trigger lock until the done event when the interrupt is enabled.
// Assumes frame_done_i and start_o are never high in the same cycle.
module p8080_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_we_i,
    input  logic ctl_mode_i,
    input  logic ctl_cmd_i,
    input  logic ctl_hwen_i,
    input  logic ctl_mask_i,
    input  logic ctl_every_i,
    input  logic if_en_i,
    input  logic irq_en_i,
    input  logic te_rise_i,
    input  logic xfer_active_i,
    input  logic frame_done_i,
    output logic start_o,
    output logic busy_o
);

    logic hwen_q, mask_q, every_q, armed_q, lock_q;
    logic sw_fire, hw_fire;

    assign sw_fire = ctl_we_i & ctl_mode_i & ctl_cmd_i;
    assign hw_fire = te_rise_i & hwen_q & ~mask_q & (every_q | armed_q);
    assign start_o = if_en_i & ~xfer_active_i & ~lock_q & (sw_fire | hw_fire);
    assign busy_o  = lock_q;

    // stored hardware trigger controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hwen_q  <= 1'b0;
            mask_q  <= 1'b0;
            every_q <= 1'b0;
        end else if (ctl_we_i) begin
            hwen_q  <= ctl_hwen_i;
            mask_q  <= ctl_mask_i;
            every_q <= ctl_every_i;
        end
    end

    // one-shot arming for the single-pulse hardware mode
    always_ff @(posedge clk) begin
        if (!rst_n)                  armed_q <= 1'b0;
        else if (ctl_we_i)           armed_q <= ctl_hwen_i;
        else if (start_o && hw_fire) armed_q <= 1'b0;
    end

    // trigger lock, released only by the done event
    always_ff @(posedge clk) begin
        if (!rst_n)                   lock_q <= 1'b0;
        else if (frame_done_i)        lock_q <= 1'b0;
        else if (start_o && irq_en_i) lock_q <= 1'b1;
    end

endmodule

// File: rtl/p8080_frame_ctl.sv
// Frame controller: counts the pixel words left in the frame, captures the
// phase lengths at frame start and flags the done event once the last write
// cycle has closed. Assumes a start cannot coincide with a handshake.
module p8080_frame_ctl
    import p8080_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] flen_i,
    input  phase_cfg_t       cfg_live_i,
    input  logic             pix_hs_i,
    input  logic             seq_idle_i,
    output logic             xfer_active_o,
    output logic             want_pix_o,
    output logic             done_o,
    output phase_cfg_t       cfg_frame_o
);

    logic             xfer_q;
    logic [LEN_W-1:0] left_q;
    phase_cfg_t       cfg_q;

    assign xfer_active_o = xfer_q;
    assign want_pix_o    = xfer_q & (left_q != '0);
    assign done_o        = xfer_q & (left_q == '0) & seq_idle_i;
    assign cfg_frame_o   = cfg_q;

    // frame state, word countdown and phase snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_q <= 1'b0;
            left_q <= '0;
            cfg_q  <= '0;
        end else if (start_i) begin
            xfer_q <= 1'b1;
            left_q <= flen_i;
            cfg_q  <= cfg_live_i;
        end else begin
            if (done_o)   xfer_q <= 1'b0;
            if (pix_hs_i) left_q <= left_q - 1'b1;
        end
    end

endmodule

// File: rtl/p8080_strobe.sv
// Write-cycle sequencer: takes one pixel from the stream while the bus is
// idle, then walks select setup, strobe setup, strobe active and hold, each
// lasting its field value plus one cycle. Assumes cfg_i is stable per frame.
module p8080_strobe
    import p8080_pkg::*;
#(
    parameter int PIX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_cfg_t       cfg_i,
    input  logic             go_i,
    input  logic             pix_valid_i,
    input  logic [PIX_W-1:0] pix_data_i,
    output logic             pix_ready_o,
    output logic             pix_hs_o,
    output logic             idle_o,
    output logic             cs_n_o,
    output logic             wr_n_o,
    output logic [PIX_W-1:0] data_o
);

    phase_e           phase_q;
    logic [PH_W-1:0]  cnt_q;
    logic [PIX_W-1:0] data_q;
    logic             cnt_zero;

    assign cnt_zero    = (cnt_q == '0);
    assign idle_o      = (phase_q == PH_IDLE);
    assign pix_ready_o = go_i & idle_o;
    assign pix_hs_o    = pix_ready_o & pix_valid_i;
    assign cs_n_o      = idle_o;
    assign wr_n_o      = (phase_q != PH_WRACT);
    assign data_o      = data_q;

    // phase walk with per-phase countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (pix_hs_o) begin
                    phase_q <= PH_CSSET;
                    cnt_q   <= cfg_i.cs_setup;
                end
                PH_CSSET: if (cnt_zero) begin
                    phase_q <= PH_WRSET;
                    cnt_q   <= cfg_i.wr_setup;
                end else cnt_q <= cnt_q - 1'b1;
                PH_WRSET: if (cnt_zero) begin
                    phase_q <= PH_WRACT;
                    cnt_q   <= cfg_i.wr_active;
                end else cnt_q <= cnt_q - 1'b1;
                PH_WRACT: if (cnt_zero) begin
                    phase_q <= PH_HOLD;
                    cnt_q   <= cfg_i.wr_hold;
                end else cnt_q <= cnt_q - 1'b1;
                PH_HOLD: if (cnt_zero) begin
                    phase_q <= PH_IDLE;
                end else cnt_q <= cnt_q - 1'b1;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // bus data register loaded on each accepted pixel
    always_ff @(posedge clk) begin
        if (!rst_n)        data_q <= '0;
        else if (pix_hs_o) data_q <= pix_data_i;
    end

endmodule

// File: rtl/p8080_write_engine.sv
// Top of the 8080 panel write engine: holds the programmable words, the
// sticky done-pending bit and the interrupt gate, and wires the trigger
// arbiter, frame controller, sequencer and tearing-effect synchroniser.
// Assumes single-cycle register writes and an asynchronous te_i.
module p8080_write_engine
    import p8080_pkg::*;
#(
    parameter int PIX_W   = 16,
    parameter int LEN_W   = 16,
    parameter int TE_SYNC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we_i,
    input  logic [2:0]       reg_addr_i,
    input  logic [31:0]      reg_wdata_i,
    input  logic             te_i,
    input  logic             pix_valid_i,
    input  logic [PIX_W-1:0] pix_data_i,
    output logic             pix_ready_o,
    output logic             lcd_cs_n_o,
    output logic             lcd_wr_n_o,
    output logic [PIX_W-1:0] lcd_data_o,
    output logic             trig_busy_o,
    output logic             irq_pend_o,
    output logic             irq_o
);

    logic             if_en_q, irq_en_q, pend_q;
    phase_cfg_t       cfg_q, cfg_frame;
    logic [LEN_W-1:0] flen_q;
    logic             we_cfg, we_trig, we_len, we_irqen, clr_pend;
    logic             te_rise, start, xfer_active, want_pix, frame_done;
    logic             pix_hs, seq_idle;
    logic             unused_wdata;

    assign we_cfg   = reg_we_i & (reg_addr_i == A_IFCFG);
    assign we_trig  = reg_we_i & (reg_addr_i == A_TRIG);
    assign we_len   = reg_we_i & (reg_addr_i == A_FLEN);
    assign we_irqen = reg_we_i & (reg_addr_i == A_IRQEN);
    assign clr_pend = reg_we_i & (reg_addr_i == A_IRQCLR) & reg_wdata_i[0];
    assign unused_wdata = ^reg_wdata_i;

    // interface configuration word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if_en_q <= 1'b0;
            cfg_q   <= '0;
        end else if (we_cfg) begin
            if_en_q         <= reg_wdata_i[CFG_EN_BIT];
            cfg_q.cs_setup  <= reg_wdata_i[CFG_CSSET_LSB +: PH_W];
            cfg_q.wr_setup  <= reg_wdata_i[CFG_WSET_LSB  +: PH_W];
            cfg_q.wr_active <= reg_wdata_i[CFG_ACT_LSB   +: PH_W];
            cfg_q.wr_hold   <= reg_wdata_i[CFG_HOLD_LSB  +: PH_W];
        end
    end

    // frame length and interrupt enable words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flen_q   <= '0;
            irq_en_q <= 1'b0;
        end else begin
            if (we_len)   flen_q   <= reg_wdata_i[LEN_W-1:0];
            if (we_irqen) irq_en_q <= reg_wdata_i[0];
        end
    end

    // sticky done-pending bit; a done event wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (frame_done) pend_q <= 1'b1;
        else if (clr_pend)   pend_q <= 1'b0;
    end

    assign irq_pend_o = pend_q;
    assign irq_o      = pend_q & irq_en_q;

    p8080_te_sync #(.STAGES(TE_SYNC)) u_te_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .te_i      (te_i),
        .te_rise_o (te_rise)
    );

    p8080_trigger u_trigger (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_we_i      (we_trig),
        .ctl_mode_i    (reg_wdata_i[TRG_MODE_BIT]),
        .ctl_cmd_i     (reg_wdata_i[TRG_CMD_BIT]),
        .ctl_hwen_i    (reg_wdata_i[TRG_HWEN_BIT]),
        .ctl_mask_i    (reg_wdata_i[TRG_MASK_BIT]),
        .ctl_every_i   (reg_wdata_i[TRG_EVERY_BIT]),
        .if_en_i       (if_en_q),
        .irq_en_i      (irq_en_q),
        .te_rise_i     (te_rise),
        .xfer_active_i (xfer_active),
        .frame_done_i  (frame_done),
        .start_o       (start),
        .busy_o        (trig_busy_o)
    );

    p8080_frame_ctl #(.LEN_W(LEN_W)) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .flen_i        (flen_q),
        .cfg_live_i    (cfg_q),
        .pix_hs_i      (pix_hs),
        .seq_idle_i    (seq_idle),
        .xfer_active_o (xfer_active),
        .want_pix_o    (want_pix),
        .done_o        (frame_done),
        .cfg_frame_o   (cfg_frame)
    );

    p8080_strobe #(.PIX_W(PIX_W)) u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_i       (cfg_frame),
        .go_i        (want_pix),
        .pix_valid_i (pix_valid_i),
        .pix_data_i  (pix_data_i),
        .pix_ready_o (pix_ready_o),
        .pix_hs_o    (pix_hs),
        .idle_o      (seq_idle),
        .cs_n_o      (lcd_cs_n_o),
        .wr_n_o      (lcd_wr_n_o),
        .data_o      (lcd_data_o)
    );

endmodule

// File: rtl/p8080_write_engine_chk.sv
// Checker for the 8080 write engine: temporal properties over its ports and
// its frame state, attached to every instance by the bind below.
module p8080_write_engine_chk
    import p8080_pkg::*;
#(
    parameter int PIX_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             wr_n,
    input logic [PIX_W-1:0] data,
    input logic             pix_valid,
    input logic             pix_ready,
    input logic             busy,
    input logic             pend,
    input logic             xfer,
    input logic             reg_we,
    input logic [2:0]       reg_addr,
    input logic             wbit0
);

    // R2
    strobe_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !cs_n);

    // R3
    data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(data));

    // R3
    accept_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready) |-> cs_n);

    // R8
    select_only_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> xfer);

    // R9
    lock_only_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> xfer);

    // R4
    pend_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(xfer));

    // R10
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend) && !($past(reg_we) && $past(reg_addr) == A_IRQCLR && $past(wbit0))) |-> pend);

endmodule

bind p8080_write_engine p8080_write_engine_chk #(.PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (lcd_cs_n_o),
    .wr_n      (lcd_wr_n_o),
    .data      (lcd_data_o),
    .pix_valid (pix_valid_i),
    .pix_ready (pix_ready_o),
    .busy      (trig_busy_o),
    .pend      (irq_pend_o),
    .xfer      (xfer_active),
    .reg_we    (reg_we_i),
    .reg_addr  (reg_addr_i),
    .wbit0     (reg_wdata_i[0])
);

// File: tb/p8080_write_engine_bench.sv
`timescale 1ns/1ps
module p8080_write_engine_bench;

    localparam int PIX_W = 16;
    localparam time TCLK = 20ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic             te = 1'b0;
    logic             pix_valid = 1'b1;
    logic [PIX_W-1:0] pix_data = '0;
    logic             pix_ready, cs_n, wr_n, busy, pend, irq;
    logic [PIX_W-1:0] lcd_data;

    int checks = 0;
    int fails  = 0;
    int strobes = 0;
    logic pw_mon = 1'b1;

    always #(TCLK/2) clk = ~clk;

    p8080_write_engine #(.PIX_W(PIX_W), .LEN_W(16), .TE_SYNC(2)) u_p8080_write_engine (
        .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .te_i(te), .pix_valid_i(pix_valid),
        .pix_data_i(pix_data), .pix_ready_o(pix_ready), .lcd_cs_n_o(cs_n),
        .lcd_wr_n_o(wr_n), .lcd_data_o(lcd_data), .trig_busy_o(busy),
        .irq_pend_o(pend), .irq_o(irq)
    );

    // strobe counter observed on the panel bus
    always @(negedge clk) begin
        if (pw_mon && !wr_n) strobes++;
        pw_mon = wr_n;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic logic [31:0] cfg_word(input int s, input int w, input int a,
                                             input int h, input bit en);
        return {12'd0, s[3:0], w[3:0], a[3:0], h[3:0], 3'd0, en};
    endfunction

    task automatic pulse_te();
        te = 1'b1;
        repeat (3) @(negedge clk);
        te = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_pend(output bit got);
        got = 1'b0;
        for (int i = 0; i < 600; i++) begin
            if (pend) begin got = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    // follows a running frame at negedges and checks every phase length
    task automatic measure(input int s, input int w, input int a, input int h,
                           input int n, input bit exp_busy, input bit poke,
                           input logic [2:0] paddr, input logic [31:0] pval);
        int idx = 0, setup_c = 0, wlow = 0, hold_c = 0, gap = 0, since_rise = 0;
        bit pc = 1'b1, pw = 1'b1, hs_prev = 1'b0, seen_wr = 1'b0, poking = 1'b0, poked = 1'b0;
        bit done = 1'b0;
        logic [PIX_W-1:0] base = pix_data;
        for (int cyc = 0; cyc < 3000 && !done; cyc++) begin
            if (hs_prev) pix_data = pix_data + 1'b1;
            if (poking) begin reg_we = 1'b0; poking = 1'b0; end
            if (pc && !cs_n) begin
                if (idx > 0) check(gap == 1, "R3", "select high gap", gap, 1);
                setup_c = 0; seen_wr = 1'b0;
            end
            if (!cs_n && wr_n && !seen_wr) setup_c++;
            if (!wr_n) begin
                if (pw) begin
                    check(setup_c == s + w + 2, "R2", "select-to-strobe", setup_c, s + w + 2);
                    check(lcd_data == base + idx[PIX_W-1:0], "R3", "bus data", lcd_data, base + idx);
                    if (idx == 0) check(busy == exp_busy, "R9", "busy in frame", busy, exp_busy);
                    wlow = 0;
                    if (poke && !poked) begin
                        reg_we = 1'b1; reg_addr = paddr; reg_wdata = pval;
                        poking = 1'b1; poked = 1'b1;
                    end
                end
                wlow++;
            end
            if (wr_n && !pw) begin
                check(wlow == a + 1, "R2", "strobe low length", wlow, a + 1);
                hold_c = 0; seen_wr = 1'b1;
            end
            if (!cs_n && wr_n && seen_wr) hold_c++;
            if (cs_n && !pc) begin
                check(hold_c == h + 1, "R2", "hold length", hold_c, h + 1);
                idx++; gap = 0; since_rise = 0;
            end
            if (cs_n) begin gap++; since_rise++; end
            if (pend) begin
                check(idx == n, "R4", "strobes in frame", idx, n);
                check(since_rise == 2, "R4", "done delay", since_rise, 2);
                check(busy == 1'b0, "R9", "busy after done", busy, 0);
                done = 1'b1;
            end
            hs_prev = pix_valid && pix_ready;
            pc = cs_n; pw = wr_n;
            if (!done) @(negedge clk);
        end
        if (!done) check(1'b0, "R4", "frame never finished", 0, 1);
        if (poking) reg_we = 1'b0;
    endtask

    initial begin
        #(TCLK * 200000);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int vals[3] = '{0, 1, 3};
        int s0;
        bit got;
        repeat (3) @(negedge clk);
        // R1 reset values
        check(cs_n == 1 && wr_n == 1, "R1", "bus idle in reset", {cs_n, wr_n}, 3);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n == 1 && wr_n == 1, "R1", "bus idle after reset", {cs_n, wr_n}, 3);
        check(pix_ready == 0 && busy == 0, "R1", "ready/busy low", {pix_ready, busy}, 0);
        check(pend == 0 && irq == 0, "R1", "interrupt low", {pend, irq}, 0);

        // R2 R3 R4 R5 sweep of phase lengths, software trigger
        wr_reg(A_IRQEN_C(), 32'd1);
        wr_reg(3'd2, 32'd2);
        for (int si = 0; si < 3; si++)
            for (int wi = 0; wi < 3; wi++)
                for (int ai = 0; ai < 3; ai++)
                    for (int hi = 0; hi < 3; hi++) begin
                        wr_reg(3'd0, cfg_word(vals[si], vals[wi], vals[ai], vals[hi], 1'b1));
                        wr_reg(3'd1, 32'h3);
                        measure(vals[si], vals[wi], vals[ai], vals[hi], 2, 1'b1, 1'b0, 3'd0, 32'd0);
                        check(irq == 1, "R10", "irq with enable", irq, 1);
                        wr_reg(3'd4, 32'd1);
                        check(pend == 0 && irq == 0, "R10", "clear pending", pend, 0);
                    end

        // R4 zero-length frame
        wr_reg(3'd2, 32'd0);
        s0 = strobes;
        wr_reg(3'd1, 32'h3);
        check(pend == 0, "R4", "zero length first cycle", pend, 0);
        @(negedge clk);
        check(pend == 1, "R4", "zero length done", pend, 1);
        check(strobes == s0, "R4", "zero length strobes", strobes - s0, 0);
        wr_reg(3'd4, 32'd1);

        // R5 command bit without mode bit
        wr_reg(3'd2, 32'd1);
        s0 = strobes;
        wr_reg(3'd1, 32'h2);
        repeat (30) @(negedge clk);
        check(strobes == s0 && pend == 0, "R5", "command without mode", strobes - s0, 0);

        // R12 interface disabled
        wr_reg(3'd0, cfg_word(1, 1, 1, 1, 1'b0));
        wr_reg(3'd1, 32'h3);
        repeat (30) @(negedge clk);
        check(strobes == s0 && pend == 0, "R12", "disabled interface", strobes - s0, 0);
        wr_reg(3'd0, cfg_word(1, 0, 2, 1, 1'b1));

        // R8 software trigger inside a running frame
        wr_reg(3'd2, 32'd3);
        wr_reg(3'd1, 32'h3);
        measure(1, 0, 2, 1, 3, 1'b1, 1'b1, 3'd1, 32'h3);
        s0 = strobes;
        repeat (40) @(negedge clk);
        check(strobes == s0 && cs_n == 1, "R8", "no second frame", strobes - s0, 0);
        wr_reg(3'd4, 32'd1);

        // R13 configuration write during a frame
        wr_reg(3'd1, 32'h3);
        measure(1, 0, 2, 1, 3, 1'b1, 1'b1, 3'd0, cfg_word(2, 1, 5, 0, 1'b1));
        wr_reg(3'd4, 32'd1);
        wr_reg(3'd1, 32'h3);
        measure(2, 1, 5, 0, 3, 1'b1, 1'b0, 3'd0, 32'd0);
        wr_reg(3'd4, 32'd1);

        // R9 busy stays low without interrupt enable; R10 gating
        wr_reg(3'd3, 32'd0);
        wr_reg(3'd2, 32'd1);
        wr_reg(3'd1, 32'h3);
        measure(2, 1, 5, 0, 1, 1'b0, 1'b0, 3'd0, 32'd0);
        check(irq == 0 && pend == 1, "R10", "irq gated off", irq, 0);
        wr_reg(3'd3, 32'd1);
        check(irq == 1, "R10", "irq after enable", irq, 1);
        wr_reg(3'd4, 32'd0);
        check(pend == 1, "R10", "clear with bit0 low ignored", pend, 1);
        wr_reg(3'd4, 32'd1);
        check(pend == 0, "R10", "clear with bit0 high", pend, 0);

        // R6 tearing-effect trigger, every pulse mode, then masked
        wr_reg(3'd0, cfg_word(0, 0, 1, 0, 1'b1));
        wr_reg(3'd1, 32'h8000_0008);
        s0 = strobes;
        pulse_te();
        wait_pend(got);
        check(got && strobes == s0 + 1, "R6", "te starts frame", strobes - s0, 1);
        wr_reg(3'd4, 32'd1);
        wr_reg(3'd1, 32'h8000_0018);
        s0 = strobes;
        pulse_te();
        repeat (40) @(negedge clk);
        check(strobes == s0 && pend == 0, "R6", "masked te", strobes - s0, 0);

        // R7 single-pulse mode needs re-arming
        wr_reg(3'd1, 32'h0000_0008);
        s0 = strobes;
        pulse_te();
        wait_pend(got);
        check(got && strobes == s0 + 1, "R7", "armed pulse", strobes - s0, 1);
        wr_reg(3'd4, 32'd1);
        s0 = strobes;
        pulse_te();
        repeat (40) @(negedge clk);
        check(strobes == s0 && pend == 0, "R7", "unarmed pulse", strobes - s0, 0);
        wr_reg(3'd1, 32'h0000_0008);
        pulse_te();
        wait_pend(got);
        check(got && strobes == s0 + 1, "R7", "re-armed pulse", strobes - s0, 1);
        wr_reg(3'd4, 32'd1);

        // R8 tearing-effect edge inside a running frame
        wr_reg(3'd1, 32'h8000_0008);
        wr_reg(3'd0, cfg_word(3, 3, 6, 3, 1'b1));
        wr_reg(3'd2, 32'd2);
        s0 = strobes;
        pulse_te();
        pulse_te();
        wait_pend(got);
        repeat (40) @(negedge clk);
        check(got && strobes == s0 + 2, "R8", "te during frame", strobes - s0, 2);
        wr_reg(3'd1, 32'h0);
        wr_reg(3'd4, 32'd1);

        // R11 done event and clear in the same cycle
        wr_reg(3'd0, cfg_word(1, 1, 1, 2, 1'b1));
        wr_reg(3'd2, 32'd1);
        wr_reg(3'd1, 32'h3);
        begin
            bit pwl = 1'b1;
            for (int i = 0; i < 200; i++) begin
                if (wr_n && !pwl) break;
                pwl = wr_n;
                @(negedge clk);
            end
        end
        repeat (3) @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'd1;
        @(negedge clk);
        reg_we = 1'b0;
        check(pend == 1 && irq == 1, "R11", "set wins over clear", pend, 1);
        wr_reg(3'd4, 32'd1);
        check(pend == 0, "R11", "later clear", pend, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    function automatic logic [2:0] A_IRQEN_C();
        return 3'd3;
    endfunction

endmodule